// File: doc/BRIEF.md
# Dual-Issue SIMT Warp Scheduler

This block chooses which warps issue each cycle in a multithreaded SIMT core. The resident warps are split between two schedulers: one owns the even warp ids and the other owns the odd ones. In every cycle each scheduler makes a round-robin choice among its warps that are ready and whose target execution group is free. The three execution groups are a 16-lane arithmetic group, a 16-lane load/store group and a 4-lane special-function group. Both schedulers can issue in the same cycle when they target different groups. When they want the same free group, a two-state arbiter grants it, and the scheduler that lost the previous such conflict wins. The arbiter states are `ARB_FAV0` and `ARB_FAV1`. A conflict moves the arbiter to the other state. When there is no conflict, the state does not change.

Each warp keeps an active-thread mask and a reconvergence stack. A branch event whose taken mask splits the active threads pushes an entry and narrows the mask to the taken threads. The entry holds the join point and the threads still pending. The first join event switches the warp to the pending threads. The second join event merges both sets again and pops the entry. Issue outputs are registered. They carry the warp id, the mask in force at the moment of the decision, and the group the instruction goes to.

Fetch, decode, operand collection and the datapaths sit around this block. They supply readiness, instruction class and branch/join events, and they see the decisions through the issue outputs.

Top module: `simt_dual_issue_sched`

## Requirements
- R1: After reset there is no issue, every overflow flag is clear, `evt_rpc` reads 0, and every warp's active mask is all ones.
- R2: Scheduler 0 issues only even warp ids and scheduler 1 issues only odd warp ids.
- R3: Each scheduler picks the first eligible warp, searching upward with wraparound from the warp after its last issued warp. The search starts at its lowest warp after reset. The decision made from the inputs of cycle t appears on the outputs after the clock edge that ends cycle t.
- R4: Class codes per warp are 0 = arithmetic, 1 = load/store, 2 = special function and 3 = none. A class-3 warp never issues. A group whose `unit_busy` bit is high (bit 0 arithmetic, bit 1 load/store, bit 2 special function) accepts no issue in that cycle.
- R5: An issue occupies the arithmetic or load/store group for 2 cycles and the special-function group for 8 cycles. During that time no other issue to the group takes place.
- R6: The two schedulers issue in the same cycle when they target different groups. When they target the same group, only one issues: scheduler 0 wins the first conflict after reset, and after that the loser of the previous conflict wins.
- R7: A branch event with taken mask M splits warp w when M AND active is neither zero nor equal to active. In that case the active mask becomes M AND active, and the issue mask shows it. Any other branch event leaves the mask and stack unchanged.
- R8: The first join on a split entry makes the pending threads active. The second join restores the union of both paths and pops the entry. A join on an empty stack has no effect.
- R9: The stack holds 8 entries. A split branch on a full stack sets the warp's sticky overflow flag and leaves its mask and stack unchanged.
- R10: `evt_rpc` shows the join point stored at the top of the stack of warp `evt_warp`, or 0 when that stack is empty or the id is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | 48 | Per-warp ready bit |
| warp_class | input | 96 | Per-warp 2-bit class code, warp w at bits 2w+1:2w |
| unit_busy | input | 3 | External busy per group |
| evt_kind | input | 2 | 0 none, 1 branch, 2 join, 3 none |
| evt_warp | input | 6 | Warp id the event applies to |
| evt_mask | input | 32 | Taken-thread mask of a branch |
| evt_pc | input | 16 | Join point pushed by a splitting branch |
| evt_rpc | output | 16 | Top-of-stack join point of `evt_warp` |
| warp_ovf | output | 48 | Sticky per-warp stack overflow |
| iss_valid | output | 2 | Issue strobe per scheduler |
| iss_warp | output | 12 | Issued warp id, scheduler s at bits 6s+5:6s |
| iss_mask | output | 64 | Active mask of the issue, scheduler s at bits 32s+31:32s |
| iss_unit | output | 4 | Target group code, scheduler s at bits 2s+1:2s |

## Verification
The directed patterns cover the following cases. A single lone warp shows the group occupancy times. Three warps of one parity show the rotation order. An even/odd pair on different groups shows dual issue, and the same pair on one group shows the alternating conflict winner. A class-3 warp and a held `unit_busy` check that blocked work stays out. A split, two joins and a non-splitting branch on one warp separate the taken, pending and merged masks. Nine nested splits fill the stack and then show the overflow drop. Long random stretches of readiness, classes, busy bits and branch/join events on random warps are compared cycle by cycle with a bench model. This exposes wrong pointer updates, arbiter flips and mask bookkeeping that the directed cases might miss.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;

    typedef enum logic [1:0] {
        UG_ALU  = 2'd0,
        UG_LSU  = 2'd1,
        UG_SFU  = 2'd2,
        UG_NONE = 2'd3
    } unit_grp_e;

    typedef enum logic [1:0] {
        EVK_IDLE   = 2'd0,
        EVK_BRANCH = 2'd1,
        EVK_JOIN   = 2'd2,
        EVK_RSVD   = 2'd3
    } evt_kind_e;

    typedef enum logic {
        ARB_FAV0 = 1'b0,
        ARB_FAV1 = 1'b1
    } arb_state_e;

endpackage

// File: rtl/ss_unit_timer.sv
module ss_unit_timer #(
    parameter int OCC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ext_busy,
    output logic free
);
    localparam int CW = $clog2(OCC) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(OCC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign free = !ext_busy && (cnt == '0);

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0 && !ext_busy)) else $error("group started while occupied"); // R5

endmodule

// File: rtl/ss_rr_pick.sv
module ss_rr_pick #(
    parameter int N = 24
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] last,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Walk from farthest to nearest so the nearest hit is assigned last.
    always_comb begin
        int pos;
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int k = N; k >= 1; k--) begin
            pos = (int'(last) + k) % N;
            if (req[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/ss_reconv_stack.sv
module ss_reconv_stack #(
    parameter int THREADS = 32,
    parameter int DEPTH   = 8,
    parameter int PC_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br,
    input  logic               jn,
    input  logic [THREADS-1:0] ev_mask,
    input  logic [PC_W-1:0]    ev_pc,
    output logic [THREADS-1:0] act,
    output logic [PC_W-1:0]    top_pc,
    output logic               ovf
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IXW = $clog2(DEPTH);

    logic [PC_W-1:0]    ent_pc   [DEPTH];
    logic [THREADS-1:0] ent_mask [DEPTH];
    logic [DEPTH-1:0]   ent_ph;
    logic [SPW-1:0]     sp;
    logic [IXW-1:0]     top_ix, push_ix;
    logic [THREADS-1:0] taken;
    logic               split, full, empty, do_push, do_swap, do_pop;

    assign taken   = ev_mask & act;
    assign split   = (taken != '0) && (taken != act);
    assign full    = (sp == SPW'(DEPTH));
    assign empty   = (sp == '0);
    assign top_ix  = IXW'(sp - 1'b1);
    assign push_ix = IXW'(sp);
    assign do_push = br && split && !full;
    assign do_swap = !br && jn && !empty && !ent_ph[top_ix];
    assign do_pop  = !br && jn && !empty &&  ent_ph[top_ix];
    assign top_pc  = empty ? '0 : ent_pc[top_ix];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            act <= '1;
            ovf <= 1'b0;
        end else if (br && split && full) begin
            ovf <= 1'b1;
        end else if (do_push) begin
            act <= taken;
            sp  <= sp + 1'b1;
        end else if (do_swap) begin
            act <= ent_mask[top_ix];
        end else if (do_pop) begin
            act <= act | ent_mask[top_ix];
            sp  <= sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            ent_pc[push_ix]   <= ev_pc;
            ent_mask[push_ix] <= act & ~taken;
            ent_ph[push_ix]   <= 1'b0;
        end else if (do_swap) begin
            ent_mask[top_ix]  <= act;
            ent_ph[top_ix]    <= 1'b1;
        end
    end

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SPW'(DEPTH)) else $error("stack pointer past depth"); // R9
    AST_ACTIVE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        act != '0) else $error("warp lost every thread"); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf) else $error("overflow flag dropped"); // R9
    AST_FULL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (br && split && full) |=> $stable(act)) else $error("mask changed on full push"); // R9

endmodule

// File: rtl/simt_dual_issue_sched.sv
module simt_dual_issue_sched
    import simt_sched_pkg::*;
#(
    parameter int NUM_WARPS    = 48,
    parameter int WARP_THREADS = 32,
    parameter int STACK_DEPTH  = 8,
    parameter int PC_W         = 16,
    parameter int ALU_LANES    = 16,
    parameter int LSU_LANES    = 16,
    parameter int SFU_LANES    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          warp_ready,
    input  logic [2*NUM_WARPS-1:0]        warp_class,
    input  logic [2:0]                    unit_busy,
    input  logic [1:0]                    evt_kind,
    input  logic [$clog2(NUM_WARPS)-1:0]  evt_warp,
    input  logic [WARP_THREADS-1:0]       evt_mask,
    input  logic [PC_W-1:0]               evt_pc,
    output logic [PC_W-1:0]               evt_rpc,
    output logic [NUM_WARPS-1:0]          warp_ovf,
    output logic [1:0]                    iss_valid,
    output logic [2*$clog2(NUM_WARPS)-1:0] iss_warp,
    output logic [2*WARP_THREADS-1:0]     iss_mask,
    output logic [3:0]                    iss_unit
);
    localparam int WID_W   = $clog2(NUM_WARPS);
    localparam int HALF    = NUM_WARPS / 2;
    localparam int HIW     = $clog2(HALF);
    localparam int ALU_OCC = WARP_THREADS / ALU_LANES;
    localparam int LSU_OCC = WARP_THREADS / LSU_LANES;
    localparam int SFU_OCC = WARP_THREADS / SFU_LANES;
    localparam int GAP_W   = $clog2(SFU_OCC) + 1;

    logic [WARP_THREADS-1:0] act_all    [NUM_WARPS];
    logic [PC_W-1:0]         top_pc_all [NUM_WARPS];
    logic [2:0]              unit_free, unit_start;
    logic [3:0]              unit_ok;
    logic [1:0]              found, grant;
    logic [WID_W-1:0]        cand_w   [2];
    logic [1:0]              cand_cls [2];
    logic                    conflict;
    arb_state_e              arb_q, arb_d;

    assign unit_ok = {1'b0, unit_free};

    // ---------------- per-warp divergence state ----------------
    generate
        for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
            ss_reconv_stack #(
                .THREADS (WARP_THREADS),
                .DEPTH   (STACK_DEPTH),
                .PC_W    (PC_W)
            ) u_stk (
                .clk     (clk),
                .rst_n   (rst_n),
                .br      (evt_kind == EVK_BRANCH && int'(evt_warp) == w),
                .jn      (evt_kind == EVK_JOIN   && int'(evt_warp) == w),
                .ev_mask (evt_mask),
                .ev_pc   (evt_pc),
                .act     (act_all[w]),
                .top_pc  (top_pc_all[w]),
                .ovf     (warp_ovf[w])
            );
        end
    endgenerate

    assign evt_rpc = (int'(evt_warp) < NUM_WARPS) ? top_pc_all[evt_warp] : '0;

    // ---------------- execution group occupancy ----------------
    generate
        for (genvar u = 0; u < 3; u++) begin : g_unit
            localparam int OCC_U = (u == 0) ? ALU_OCC : (u == 1) ? LSU_OCC : SFU_OCC;
            ss_unit_timer #(.OCC(OCC_U)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (unit_start[u]),
                .ext_busy (unit_busy[u]),
                .free     (unit_free[u])
            );
        end
    endgenerate

    // ---------------- two parity schedulers ----------------
    generate
        for (genvar s = 0; s < 2; s++) begin : g_sched
            logic [HALF-1:0] req;
            logic [HIW-1:0]  last_q, pidx;

            always_comb begin
                for (int i = 0; i < HALF; i++) begin
                    req[i] = warp_ready[2*i+s]
                          && (warp_class[2*(2*i+s) +: 2] != UG_NONE)
                          && unit_ok[warp_class[2*(2*i+s) +: 2]];
                end
            end

            ss_rr_pick #(.N(HALF)) u_pick (
                .req   (req),
                .last  (last_q),
                .found (found[s]),
                .idx   (pidx)
            );

            assign cand_w[s]   = {pidx, 1'(s)};
            assign cand_cls[s] = warp_class[2*cand_w[s] +: 2];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    last_q <= HIW'(HALF - 1);
                end else if (grant[s]) begin
                    last_q <= pidx;
                end
            end
        end
    endgenerate

    // ---------------- conflict arbiter FSM ----------------
    assign conflict = found[0] && found[1] && (cand_cls[0] == cand_cls[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= ARB_FAV0;
        else        arb_q <= arb_d;
    end

    always_comb begin
        arb_d    = arb_q;
        grant[0] = found[0];
        grant[1] = found[1];
        unique case (arb_q)
            ARB_FAV0: begin
                if (conflict) begin
                    grant[1] = 1'b0;
                    arb_d    = ARB_FAV1;
                end
            end
            ARB_FAV1: begin
                if (conflict) begin
                    grant[0] = 1'b0;
                    arb_d    = ARB_FAV0;
                end
            end
        endcase
    end

    always_comb begin
        for (int u = 0; u < 3; u++) begin
            unit_start[u] = (grant[0] && int'(cand_cls[0]) == u)
                         || (grant[1] && int'(cand_cls[1]) == u);
        end
    end

    // ---------------- registered issue outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_valid <= '0;
            iss_warp  <= '0;
            iss_mask  <= '0;
            iss_unit  <= '0;
        end else begin
            iss_valid <= grant;
            for (int s = 0; s < 2; s++) begin
                if (grant[s]) begin
                    iss_warp[s*WID_W +: WID_W]               <= cand_w[s];
                    iss_mask[s*WARP_THREADS +: WARP_THREADS] <= act_all[cand_w[s]];
                    iss_unit[s*2 +: 2]                       <= cand_cls[s];
                end
            end
        end
    end

    // ---------------- checks on the issue stream ----------------
    logic [GAP_W-1:0] chk_gap;
    logic             sfu_out;

    assign sfu_out = (iss_valid[0] && iss_unit[1:0] == UG_SFU)
                  || (iss_valid[1] && iss_unit[3:2] == UG_SFU);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              chk_gap <= '0;
        else if (sfu_out)        chk_gap <= GAP_W'(SFU_OCC - 1);
        else if (chk_gap != '0)  chk_gap <= chk_gap - 1'b1;
    end

    AST_EVEN_ODD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[0] |-> !iss_warp[0]) and (iss_valid[1] |-> iss_warp[WID_W])) else $error("parity broken"); // R2
    AST_NO_SHARED_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (&iss_valid) |-> (iss_unit[1:0] != iss_unit[3:2])) else $error("two issues to one group"); // R6
    AST_NO_CLASS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[0] |-> iss_unit[1:0] != UG_NONE) and (iss_valid[1] |-> iss_unit[3:2] != UG_NONE)) else $error("class none issued"); // R4
    AST_SFU_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sfu_out |-> (chk_gap == '0)) else $error("special group reissued early"); // R5

endmodule

// File: tb/tb_simt_dual_issue_sched.sv
module tb_simt_dual_issue_sched;
    localparam int NW = 48;
    localparam int T  = 32;
    localparam int HALF = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] warp_ready = '0;
    logic [2*NW-1:0] warp_class = '0;
    logic [2:0]    unit_busy = '0;
    logic [1:0]    evt_kind = '0;
    logic [5:0]    evt_warp = '0;
    logic [T-1:0]  evt_mask = '0;
    logic [15:0]   evt_pc = '0;
    logic [15:0]   evt_rpc;
    logic [NW-1:0] warp_ovf;
    logic [1:0]    iss_valid;
    logic [11:0]   iss_warp;
    logic [63:0]   iss_mask;
    logic [3:0]    iss_unit;

    always #10 clk = ~clk;

    simt_dual_issue_sched dut (
        .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_class(warp_class),
        .unit_busy(unit_busy), .evt_kind(evt_kind), .evt_warp(evt_warp),
        .evt_mask(evt_mask), .evt_pc(evt_pc), .evt_rpc(evt_rpc), .warp_ovf(warp_ovf),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_mask(iss_mask), .iss_unit(iss_unit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic [T-1:0]  m_act [NW];
    logic [15:0]   m_spc [NW][8];
    logic [T-1:0]  m_smk [NW][8];
    bit            m_sph [NW][8];
    int            m_sp  [NW];
    logic [NW-1:0] m_ovf;
    int            m_last [2];
    int            m_cnt [3];
    int            m_fav;
    bit            e_valid [2];
    int            e_warp [2];
    logic [T-1:0]  e_mask [2];
    int            e_unit [2];

    function automatic int occ_of(input int u);
        return (u == 2) ? 8 : 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic model_init();
        for (int w = 0; w < NW; w++) begin
            m_act[w] = '1;
            m_sp[w]  = 0;
        end
        m_ovf = '0;
        m_last[0] = HALF - 1;
        m_last[1] = HALF - 1;
        for (int u = 0; u < 3; u++) m_cnt[u] = 0;
        m_fav = 0;
    endtask

    function automatic logic [15:0] model_rpc();
        int w;
        w = int'(evt_warp);
        if (w >= NW || m_sp[w] == 0) return 16'h0;
        return m_spc[w][m_sp[w]-1];
    endfunction

    task automatic model_step();
        bit fnd [2];
        int pw [2];
        int cu [2];
        bit gr [2];
        bit conf;
        for (int s = 0; s < 2; s++) begin
            fnd[s] = 0; pw[s] = 0; cu[s] = 3;
            for (int k = 1; k <= HALF; k++) begin
                int i; int w; int c;
                i = (m_last[s] + k) % HALF;
                w = 2*i + s;
                c = int'(warp_class[2*w +: 2]);
                if (!fnd[s] && warp_ready[w] && c != 3 && !unit_busy[c] && m_cnt[c] == 0) begin
                    fnd[s] = 1; pw[s] = i; cu[s] = c;
                end
            end
        end
        conf  = fnd[0] && fnd[1] && (cu[0] == cu[1]);
        gr[0] = fnd[0] && (!conf || m_fav == 0);
        gr[1] = fnd[1] && (!conf || m_fav == 1);
        for (int s = 0; s < 2; s++) begin
            e_valid[s] = gr[s];
            if (gr[s]) begin
                e_warp[s] = 2*pw[s] + s;
                e_mask[s] = m_act[e_warp[s]];
                e_unit[s] = cu[s];
                m_last[s] = pw[s];
            end
        end
        for (int u = 0; u < 3; u++) begin
            if ((gr[0] && cu[0] == u) || (gr[1] && cu[1] == u)) m_cnt[u] = occ_of(u) - 1;
            else if (m_cnt[u] > 0) m_cnt[u]--;
        end
        if (conf) m_fav = 1 - m_fav;
        if (int'(evt_warp) < NW) begin
            int w;
            logic [T-1:0] t;
            w = int'(evt_warp);
            t = evt_mask & m_act[w];
            if (evt_kind == 2'd1 && t != '0 && t != m_act[w]) begin
                if (m_sp[w] == 8) m_ovf[w] = 1'b1;
                else begin
                    m_spc[w][m_sp[w]] = evt_pc;
                    m_smk[w][m_sp[w]] = m_act[w] & ~t;
                    m_sph[w][m_sp[w]] = 0;
                    m_act[w] = t;
                    m_sp[w]++;
                end
            end else if (evt_kind == 2'd2 && m_sp[w] > 0) begin
                int top;
                logic [T-1:0] tmp;
                top = m_sp[w] - 1;
                if (!m_sph[w][top]) begin
                    tmp = m_act[w];
                    m_act[w] = m_smk[w][top];
                    m_smk[w][top] = tmp;
                    m_sph[w][top] = 1;
                end else begin
                    m_act[w] = m_act[w] | m_smk[w][top];
                    m_sp[w]--;
                end
            end
        end
    endtask

    // inputs are set away from the edge; one clock; outputs compared 1 ns after the edge
    task automatic run_cycle();
        logic [15:0] er;
        #1;
        er = model_rpc();
        chk(evt_rpc == er, "R10 evt_rpc", 64'(evt_rpc), 64'(er));
        model_step();
        @(posedge clk);
        #1;
        for (int s = 0; s < 2; s++) begin
            chk(iss_valid[s] == e_valid[s], "R3 iss_valid", 64'(iss_valid[s]), 64'(e_valid[s]));
            if (e_valid[s] && iss_valid[s]) begin
                chk(int'(iss_warp[s*6 +: 6]) == e_warp[s], "R2 iss_warp", 64'(iss_warp[s*6 +: 6]), 64'(e_warp[s]));
                chk(iss_mask[s*32 +: 32] == e_mask[s], "R7 iss_mask", 64'(iss_mask[s*32 +: 32]), 64'(e_mask[s]));
                chk(int'(iss_unit[s*2 +: 2]) == e_unit[s], "R4 iss_unit", 64'(iss_unit[s*2 +: 2]), 64'(e_unit[s]));
            end
        end
        chk(warp_ovf == m_ovf, "R9 warp_ovf", 64'(warp_ovf), 64'(m_ovf));
    endtask

    task automatic quiet();
        warp_ready = '0;
        evt_kind = 2'd0;
        unit_busy = '0;
    endtask

    task automatic idle(input int n);
        quiet();
        for (int k = 0; k < n; k++) run_cycle();
    endtask

    task automatic set_cls(input int w, input int c);
        warp_class[2*w +: 2] = 2'(c);
    endtask

    task automatic send_evt(input int kind, input int w, input logic [T-1:0] m, input logic [15:0] pc);
        quiet();
        evt_kind = 2'(kind); evt_warp = 6'(w); evt_mask = m; evt_pc = pc;
        run_cycle();
        evt_kind = 2'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [T-1:0] t;
        int hits;
        void'($urandom(32'd20240611));
        model_init();
        repeat (3) @(posedge clk);
        #1;
        chk(iss_valid == 2'b00, "R1 no issue in reset", 64'(iss_valid), 64'h0);
        chk(warp_ovf == '0, "R1 overflow clear", 64'(warp_ovf), 64'h0);
        chk(evt_rpc == 16'h0, "R1 rpc zero", 64'(evt_rpc), 64'h0);
        rst_n = 1'b1;

        // R5: arithmetic occupancy, lone even warp 0
        set_cls(0, 0); warp_ready[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            run_cycle();
            chk(iss_valid[0] == ((k % 2) == 0), "R5 alu every 2 cycles", 64'(iss_valid[0]), 64'((k % 2) == 0));
            if (k == 0) chk(iss_mask[31:0] == 32'hFFFF_FFFF, "R1 full mask after reset", 64'(iss_mask[31:0]), 64'hFFFF_FFFF);
        end
        idle(8);

        // R5: special-function occupancy, warp 2
        set_cls(2, 2); warp_ready[2] = 1'b1;
        hits = 0;
        for (int k = 0; k < 16; k++) begin
            run_cycle();
            if (iss_valid[0]) hits++;
            chk(iss_valid[0] == (k == 0 || k == 8), "R5 sfu every 8 cycles", 64'(iss_valid[0]), 64'(k == 0 || k == 8));
        end
        chk(hits == 2, "R5 sfu issue count", 64'(hits), 64'd2);
        idle(8);

        // R3: rotation among warps 0,2,4 after last issued warp 2
        set_cls(0, 0); set_cls(2, 0); set_cls(4, 0);
        warp_ready[0] = 1'b1; warp_ready[2] = 1'b1; warp_ready[4] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            run_cycle();
            if (k % 2 == 0) begin
                int ew;
                ew = (k == 0) ? 4 : (k == 2) ? 0 : 2;
                chk(iss_valid[0] && int'(iss_warp[5:0]) == ew, "R3 round-robin order", 64'(iss_warp[5:0]), 64'(ew));
            end
        end
        idle(8);

        // R6: dual issue to different groups
        set_cls(0, 0); set_cls(1, 1);
        warp_ready[0] = 1'b1; warp_ready[1] = 1'b1;
        run_cycle();
        chk(iss_valid == 2'b11, "R6 dual issue", 64'(iss_valid), 64'h3);
        chk(iss_warp[11:6] == 6'd1 && iss_unit == 4'b0100, "R6 dual issue fields", 64'({iss_warp, iss_unit}), 64'({6'd1, 6'd0, 4'b0100}));
        idle(8);

        // R6: conflict on arithmetic group alternates the winner
        set_cls(1, 0);
        warp_ready[0] = 1'b1; warp_ready[1] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [1:0] ev;
            run_cycle();
            ev = (k == 0 || k == 4) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00;
            chk(iss_valid == ev, "R6 conflict winner", 64'(iss_valid), 64'(ev));
        end
        idle(8);

        // R4: class none and external busy
        set_cls(0, 3); warp_ready[0] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            run_cycle();
            chk(iss_valid == 2'b00, "R4 class none never issues", 64'(iss_valid), 64'h0);
        end
        set_cls(0, 0); unit_busy = 3'b001;
        for (int k = 0; k < 3; k++) begin
            run_cycle();
            chk(iss_valid == 2'b00, "R4 busy group blocks", 64'(iss_valid), 64'h0);
        end
        unit_busy = 3'b000;
        run_cycle();
        chk(iss_valid == 2'b01, "R4 issue after busy drops", 64'(iss_valid), 64'h1);
        idle(8);

        // R7/R8/R10: split, two joins on warp 4
        send_evt(1, 4, 32'h0000_FFFF, 16'h0100);
        evt_warp = 6'd4; #1;
        chk(evt_rpc == 16'h0100, "R10 top join point", 64'(evt_rpc), 64'h100);
        set_cls(4, 0); warp_ready[4] = 1'b1;
        run_cycle();
        chk(iss_valid[0] && iss_mask[31:0] == 32'h0000_FFFF, "R7 taken path mask", 64'(iss_mask[31:0]), 64'hFFFF);
        idle(2);
        send_evt(2, 4, '0, '0);
        warp_ready[4] = 1'b1;
        run_cycle();
        chk(iss_mask[31:0] == 32'hFFFF_0000, "R8 pending path mask", 64'(iss_mask[31:0]), 64'hFFFF_0000);
        idle(2);
        send_evt(2, 4, '0, '0);
        warp_ready[4] = 1'b1;
        run_cycle();
        chk(iss_mask[31:0] == 32'hFFFF_FFFF, "R8 merged mask", 64'(iss_mask[31:0]), 64'hFFFF_FFFF);
        evt_warp = 6'd4; #1;
        chk(evt_rpc == 16'h0, "R10 empty after pop", 64'(evt_rpc), 64'h0);
        idle(2);
        send_evt(1, 4, 32'hFFFF_FFFF, 16'h0200);
        send_evt(1, 4, 32'h0, 16'h0204);
        send_evt(2, 4, '0, '0);
        evt_warp = 6'd4; #1;
        chk(evt_rpc == 16'h0, "R7 non-splitting branch no push", 64'(evt_rpc), 64'h0);
        warp_ready[4] = 1'b1;
        run_cycle();
        chk(iss_mask[31:0] == 32'hFFFF_FFFF, "R7 non-splitting branch keeps mask", 64'(iss_mask[31:0]), 64'hFFFF_FFFF);
        idle(2);

        // R9: nine nested splits on warp 6
        t = '1;
        for (int n = 1; n <= 9; n++) begin
            t = t & (t - 1);
            send_evt(1, 6, t, 16'(16'h0300 + n));
            if (n == 8) chk(warp_ovf[6] == 1'b0, "R9 eight pushes fit", 64'(warp_ovf[6]), 64'h0);
        end
        chk(warp_ovf[6] == 1'b1, "R9 ninth push overflows", 64'(warp_ovf[6]), 64'h1);
        evt_warp = 6'd6; #1;
        chk(evt_rpc == 16'h0308, "R9 top kept at eighth entry", 64'(evt_rpc), 64'h308);
        set_cls(6, 0); warp_ready[6] = 1'b1;
        run_cycle();
        chk(iss_mask[31:0] == 32'hFFFF_FF00, "R9 mask unchanged by dropped push", 64'(iss_mask[31:0]), 64'hFFFF_FF00);
        idle(4);

        // random phase against the bench model
        for (int c = 0; c < 4000; c++) begin
            int r;
            warp_ready = {$urandom, $urandom} & {NW{1'b1}};
            warp_class = {$urandom, $urandom, $urandom};
            unit_busy  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            r = $urandom % 6;
            evt_kind = (r == 0) ? 2'd1 : (r == 1 || r == 2) ? 2'd2 : 2'($urandom % 4 == 0 ? 3 : 0);
            evt_warp = 6'($urandom % 50);
            evt_mask = $urandom;
            evt_pc   = 16'($urandom);
            run_cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule